// File: doc/BRIEF.md
# Multi-Mode 16-Bit Capture Timer

This block is a 16-bit down-counter with a 16-bit reload value. It runs as a plain interval timer, measures the period or the high and low widths of an external signal, or counts edges of that signal. Software reaches it over a byte-wide register port with four addresses: a control byte, the counter low byte, the counter high byte, and one unused address. One interrupt output reports that the count passed zero. A second interrupt output reports a measurement edge on the external input.

In the two measurement modes, each qualifying edge of the external input does three things in the same cycle. It reloads the counter from the reload value, it stores the count as it stood just before that reload, and it raises the edge interrupt. The stored value stays readable until software has read the full 16-bit count once. Reading the low byte copies the high byte into a shadow register, so a low-then-high read pair always returns one consistent 16-bit value while the counter keeps running.

The time base comes from one of two tick inputs: a divided system tick or a sub-clock tick, each one clock cycle wide. Clock generation and pin multiplexing are outside the block.

Top module: `capture_timer16`

## Requirements
- R1: After reset the control byte (address 0) reads 0x00, and both the counter and the reload value are 0xFFFF.
- R2: Control bit 4 selects how a byte write to address 1 (low) or address 2 (high) behaves. When it is 0, the write goes to both the reload byte and the counter byte. When it is 1, only the reload byte changes.
- R3: With mode bits [1:0]=00 (timer), the counter decrements once per tick of the selected source. Control bit 5 = 0 selects tick_div and 1 selects tick_sub; the tick on the other input has no effect.
- R4: A counting step taken at zero loads the reload value instead of decrementing, and irq_uflow is high for exactly that one cycle.
- R5: While control bit 3 (stop) is 1, counting steps do not change the counter.
- R6: With mode 01 (period), the external edge chosen by control bit 2 (0 rising, 1 falling) pulses irq_edge for one cycle and reloads the counter. The opposite edge does nothing.
- R7: On a measurement reload, the count from just before the reload is held. Reads of address 1 and 2 return the held value until address 2 has been read. Reads after that return the live count.
- R8: With mode 10 (event), the counter decrements once per external edge of the polarity chosen by control bit 2, and the tick inputs are ignored.
- R9: With mode 11 (pulse width), both rising and falling external edges pulse irq_edge and perform the hold-and-reload of R6 and R7.
- R10: A read of address 1 returns the low byte and copies the high byte into a shadow register. A read of address 2 returns that shadow, so the pair is coherent even while the counter moves.
- R11: The external input passes through a two-stage synchronizer. An input change takes effect at the third rising clock edge after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_div | input | 1 | Divided system count tick, one cycle wide |
| tick_sub | input | 1 | Sub-clock count tick, one cycle wide |
| ext_in | input | 1 | External signal for measurement or event counting |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 2 | Register address: 0 control, 1 count low, 2 count high |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, registered, valid the cycle after rd_en |
| irq_uflow | output | 1 | One-cycle pulse on underflow reload |
| irq_edge | output | 1 | One-cycle pulse on measurement edge |

## Verification
The embedded properties are checked on every cycle. They cover four things: the counter equals the reload value whenever the underflow pulse is raised, the counter stays put while stopped, edge interrupts appear only in the two measurement modes, and a held capture persists until the high-byte read. Event mode's immunity to ticks is also checked every cycle. Only the bench's scenarios can show the rest. That includes the actual measured values, the write-through versus reload-only choice, the source select, the coherence of a byte-pair read against a moving counter, and long randomized tick patterns compared with a reference count and underflow tally.

// File: rtl/ctm_pkg.sv
// Package: shared types for the capture timer.
// Assumes the control byte layout below is fixed; its bits are decoded in ctm_counter.
package ctm_pkg;

    typedef enum logic [1:0] {
        MODE_TIMER  = 2'b00,
        MODE_PERIOD = 2'b01,
        MODE_EVENT  = 2'b10,
        MODE_PULSE  = 2'b11
    } ctm_mode_e;

    // Control byte, MSB first: bit5 src_sub, bit4 latch_only, bit3 stop, bit2 pol_fall, bits1:0 mode
    typedef struct packed {
        logic      src_sub;
        logic      latch_only;
        logic      stop;
        logic      pol_fall;
        ctm_mode_e mode;
    } ctm_ctrl_t;

    localparam int CTRL_W = 6;

endpackage

// File: rtl/ctm_edge_sync.sv
// Module: ctm_edge_sync
// Brings an asynchronous pin into the clock domain through a chain of STAGES
// flip-flops, then flags single-cycle rising and falling edges.
// Assumes the pin is low during reset.
module ctm_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    output logic rise,
    output logic fall
);
    logic [STAGES-1:0] sync_q;
    logic              prev_q;

    // Synchronizer chain plus one stage for edge history.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q <= '0;
            prev_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[STAGES-2:0], pin};
            prev_q <= sync_q[STAGES-1];
        end
    end

    // Edge flags from the last synchronized stage against its history.
    assign rise = sync_q[STAGES-1] & ~prev_q;
    assign fall = ~sync_q[STAGES-1] & prev_q;

endmodule

// File: rtl/ctm_counter.sv
// Module: ctm_counter
// Down-counter, reload value, capture hold and both interrupt pulses.
// Assumes byte strobes are single-cycle. Priority on the counter: byte write >
// measurement reload > counting step. Stop halts counting steps only.
module ctm_counter
    import ctm_pkg::*;
#(
    parameter int BYTE_W = 8,
    localparam int CNT_W = 2 * BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  ctm_ctrl_t         ctrl,
    input  logic              tick_div,
    input  logic              tick_sub,
    input  logic              rise,
    input  logic              fall,
    input  logic              wr_lo,
    input  logic              wr_hi,
    input  logic              rd_hi,
    input  logic [BYTE_W-1:0] wdata,
    output logic [CNT_W-1:0]  view,
    output logic              irq_uflow,
    output logic              irq_edge
);
    logic [CNT_W-1:0] cnt_q, reload_q, cap_q;
    logic             hold_q;
    logic             sel_tick, pol_edge, step, meas;

    // Choose count source and polarity-qualified edge.
    assign sel_tick = ctrl.src_sub ? tick_sub : tick_div;
    assign pol_edge = ctrl.pol_fall ? fall : rise;

    // Decode counting step and measurement event from the mode.
    always_comb begin
        step = 1'b0;
        meas = 1'b0;
        case (ctrl.mode)
            MODE_TIMER:  step = sel_tick;
            MODE_PERIOD: begin step = sel_tick; meas = pol_edge; end
            MODE_EVENT:  step = pol_edge;
            MODE_PULSE:  begin step = sel_tick; meas = rise | fall; end
            default:     step = 1'b0;
        endcase
        if (ctrl.stop) step = 1'b0;
    end

    // Reload value: byte writes always land here.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reload_q <= '1;
        end else begin
            if (wr_lo) reload_q[BYTE_W-1:0]     <= wdata;
            if (wr_hi) reload_q[CNT_W-1:BYTE_W] <= wdata;
        end
    end

    // Counter: reload on measurement, step or wrap, then optional write-through.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q     <= '1;
            irq_uflow <= 1'b0;
        end else begin
            irq_uflow <= 1'b0;
            if (meas) begin
                cnt_q <= reload_q;
            end else if (step) begin
                if (cnt_q == '0) begin
                    cnt_q     <= reload_q;
                    irq_uflow <= 1'b1;
                end else begin
                    cnt_q <= cnt_q - 1'b1;
                end
            end
            if (wr_lo && !ctrl.latch_only) cnt_q[BYTE_W-1:0]     <= wdata;
            if (wr_hi && !ctrl.latch_only) cnt_q[CNT_W-1:BYTE_W] <= wdata;
        end
    end

    // Capture the pre-reload count and hold it until the high byte is read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_q  <= '0;
            hold_q <= 1'b0;
        end else if (meas) begin
            cap_q  <= cnt_q;
            hold_q <= 1'b1;
        end else if (rd_hi) begin
            hold_q <= 1'b0;
        end
    end

    // Edge interrupt pulse, one cycle per measurement event.
    always_ff @(posedge clk) begin
        if (!rst_n) irq_edge <= 1'b0;
        else        irq_edge <= meas;
    end

    // Read view: held capture while pending, live count otherwise.
    assign view = hold_q ? cap_q : cnt_q;

    p_uflow_reload_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_uflow && !$past(wr_lo || wr_hi)) |-> (cnt_q == reload_q));

    p_stop_holds_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(ctrl.stop) && !$past(meas) && !$past(wr_lo || wr_hi)) |-> (cnt_q == $past(cnt_q)));

    p_edge_irq_mode_r6: assert property (@(posedge clk) disable iff (!rst_n)
        irq_edge |-> ($past(ctrl.mode) == MODE_PERIOD || $past(ctrl.mode) == MODE_PULSE));

    p_hold_kept_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_q && !meas && !rd_hi) |=> (hold_q && $stable(cap_q)));

    p_event_ignores_tick_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl.mode == MODE_EVENT && !pol_edge && !wr_lo && !wr_hi) |=> $stable(cnt_q));

endmodule

// File: rtl/ctm_busif.sv
// Module: ctm_busif
// Byte register port: control register, write/read strobes, registered read
// data and the high-byte shadow. Assumes one access per cycle, reads
// take priority only in that they never alter registers other than the shadow.
module ctm_busif
    import ctm_pkg::*;
#(
    parameter int BYTE_W = 8,
    localparam int CNT_W = 2 * BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [1:0]        addr,
    input  logic [BYTE_W-1:0] wdata,
    input  logic [CNT_W-1:0]  view,
    output ctm_ctrl_t         ctrl,
    output logic              wr_lo,
    output logic              wr_hi,
    output logic              rd_hi,
    output logic [BYTE_W-1:0] rdata
);
    logic [BYTE_W-1:0] shadow_q;
    logic              rd_lo;

    // Address decode into single-cycle strobes.
    assign wr_lo = wr_en && addr == 2'd1;
    assign wr_hi = wr_en && addr == 2'd2;
    assign rd_lo = rd_en && addr == 2'd1;
    assign rd_hi = rd_en && addr == 2'd2;

    // Control register.
    always_ff @(posedge clk) begin
        if (!rst_n)                     ctrl <= '0;
        else if (wr_en && addr == 2'd0) ctrl <= ctm_ctrl_t'(wdata[CTRL_W-1:0]);
    end

    // High-byte shadow taken on the low-byte read.
    always_ff @(posedge clk) begin
        if (!rst_n)     shadow_q <= '0;
        else if (rd_lo) shadow_q <= view[CNT_W-1:BYTE_W];
    end

    // Registered read data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata <= '0;
        end else if (rd_en) begin
            case (addr)
                2'd0:    rdata <= BYTE_W'(ctrl);
                2'd1:    rdata <= view[BYTE_W-1:0];
                2'd2:    rdata <= shadow_q;
                default: rdata <= '0;
            endcase
        end
    end

    p_shadow_coherent_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rd_lo) |-> (shadow_q == $past(view[CNT_W-1:BYTE_W])));

endmodule

// File: rtl/capture_timer16.sv
// Module: capture_timer16
// Top of the multi-mode capture timer: pin synchronizer, register port and
// counting core. Assumes tick inputs are one-cycle pulses in the clk domain.
module capture_timer16 #(
    parameter int BYTE_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_div,
    input  logic              tick_sub,
    input  logic              ext_in,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [1:0]        addr,
    input  logic [BYTE_W-1:0] wdata,
    output logic [BYTE_W-1:0] rdata,
    output logic              irq_uflow,
    output logic              irq_edge
);
    localparam int CNT_W = 2 * BYTE_W;

    ctm_pkg::ctm_ctrl_t ctrl;
    logic               rise, fall, wr_lo, wr_hi, rd_hi;
    logic [CNT_W-1:0]   view;

    ctm_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .pin(ext_in), .rise(rise), .fall(fall)
    );

    ctm_busif #(.BYTE_W(BYTE_W)) u_bus (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .view(view), .ctrl(ctrl), .wr_lo(wr_lo), .wr_hi(wr_hi),
        .rd_hi(rd_hi), .rdata(rdata)
    );

    ctm_counter #(.BYTE_W(BYTE_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .ctrl(ctrl), .tick_div(tick_div),
        .tick_sub(tick_sub), .rise(rise), .fall(fall), .wr_lo(wr_lo),
        .wr_hi(wr_hi), .rd_hi(rd_hi), .wdata(wdata), .view(view),
        .irq_uflow(irq_uflow), .irq_edge(irq_edge)
    );

endmodule

// File: tb/tb_capture_timer16.sv
`timescale 1ns/1ps
// Bench: directed corner cases plus seeded random tick streams against a
// reference count model.
module tb_capture_timer16;
    logic       clk = 1'b0, rst_n = 1'b0;
    logic       tick_div = 1'b0, tick_sub = 1'b0, ext_in = 1'b0;
    logic       wr_en = 1'b0, rd_en = 1'b0;
    logic [1:0] addr = '0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic       irq_uflow, irq_edge;

    int total = 0, bad = 0, n_uf = 0, n_edge = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    capture_timer16 dut (.*);

    // Pulse tallies sampled away from the active edge.
    always @(negedge clk) begin
        if (irq_uflow) n_uf++;
        if (irq_edge)  n_edge++;
    end

    function automatic logic [7:0] ctl(input logic [1:0] mode, input bit pol_fall,
                                       input bit stop, input bit latch_only, input bit src_sub);
        return {2'b00, src_sub, latch_only, stop, pol_fall, mode};
    endfunction

    // Reference step of the counter: returns new count, bumps expected underflows.
    function automatic logic [15:0] ref_step(input logic [15:0] c, input logic [15:0] rl, inout int uf);
        if (c == 16'h0) begin uf++; return rl; end
        return c - 16'h1;
    endfunction

    task automatic check(input string req, input logic [15:0] got, input logic [15:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk); rd_en = 1'b1; addr = a;
        @(negedge clk); rd_en = 1'b0; d = rdata;
    endtask

    task automatic rd16(output logic [15:0] v);
        logic [7:0] lo, hi;
        rd(2'd1, lo); rd(2'd2, hi); v = {hi, lo};
    endtask

    task automatic wr16(input logic [15:0] v);
        wr(2'd1, v[7:0]); wr(2'd2, v[15:8]);
    endtask

    task automatic ticks(input int n, input bit sub);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); if (sub) tick_sub = 1'b1; else tick_div = 1'b1;
            @(negedge clk); tick_sub = 1'b0; tick_div = 1'b0;
        end
    endtask

    task automatic pin(input bit v);
        @(negedge clk); ext_in = v;
        repeat (5) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [7:0]  b;
        logic [15:0] v;
        int e0, u0, exp_uf;
        void'($urandom(32'h5EED_0C1A));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd(2'd0, b);  check("R1 ctrl", {8'h0, b}, 16'h0000);
        rd16(v);      check("R1 count", v, 16'hFFFF);

        // R2 write-through vs reload-only
        wr16(16'h0040);           rd16(v); check("R2 write-through", v, 16'h0040);
        wr(2'd0, ctl(2'b00, 0, 0, 1, 0));
        wr16(16'h0777);           rd16(v); check("R2 reload-only keeps count", v, 16'h0040);
        wr(2'd0, ctl(2'b00, 0, 0, 0, 0));
        wr16(16'h0003);           // count 3, reload 3

        // R3 source select and R4 underflow
        ticks(2, 1);              rd16(v); check("R3 sub tick ignored when div selected", v, 16'h0003);
        ticks(2, 0);              rd16(v); check("R3 div tick counts", v, 16'h0001);
        u0 = n_uf;
        ticks(2, 0);              rd16(v); check("R4 wrap reloads", v, 16'h0003);
        check("R4 one underflow pulse", 16'(n_uf - u0), 16'd1);
        wr(2'd0, ctl(2'b00, 0, 0, 0, 1));
        ticks(2, 1);              rd16(v); check("R3 sub tick counts when selected", v, 16'h0001);

        // R5 stop
        wr(2'd0, ctl(2'b00, 0, 1, 0, 0));
        ticks(4, 0);              rd16(v); check("R5 stopped", v, 16'h0001);

        // R6/R7 period mode, rising edge
        wr(2'd0, ctl(2'b01, 0, 0, 0, 0));
        wr16(16'h1234);
        ticks(5, 0);
        e0 = n_edge;
        pin(1'b1);                check("R6 rising edge irq", 16'(n_edge - e0), 16'd1);
        ticks(3, 0);
        rd16(v);                  check("R7 held pre-reload count", v, 16'h122F);
        rd16(v);                  check("R7 live after read", v, 16'h1231);
        e0 = n_edge;
        pin(1'b0);                check("R6 opposite edge no irq", 16'(n_edge - e0), 16'd0);
        rd16(v);                  check("R6 opposite edge no reload", v, 16'h1231);

        // R6 falling polarity
        wr(2'd0, ctl(2'b01, 1, 0, 0, 0));
        pin(1'b1);
        e0 = n_edge;
        pin(1'b0);                check("R6 falling edge irq", 16'(n_edge - e0), 16'd1);
        rd16(v);                  check("R7 held on falling", v, 16'h1231);

        // R11 synchronizer latency: irq_edge at third rising edge after change
        wr(2'd0, ctl(2'b01, 0, 0, 0, 0));
        @(negedge clk); ext_in = 1'b1;
        @(negedge clk); check("R11 no edge after 1 clk", {15'h0, irq_edge}, 16'd0);
        @(negedge clk); check("R11 no edge after 2 clk", {15'h0, irq_edge}, 16'd0);
        @(negedge clk); check("R11 edge after 3 clk", {15'h0, irq_edge}, 16'd1);
        pin(1'b0);
        rd16(v);

        // R9 pulse-width mode: both edges
        wr(2'd0, ctl(2'b11, 0, 0, 0, 0));
        wr16(16'h0100);
        e0 = n_edge;
        pin(1'b1); pin(1'b0);     check("R9 both edges irq", 16'(n_edge - e0), 16'd2);
        rd16(v);                  check("R9 capture", v, 16'h0100);

        // R8 event mode: rising edges only, ticks ignored
        wr(2'd0, ctl(2'b10, 0, 0, 0, 0));
        wr16(16'h0010);
        @(negedge clk); tick_div = 1'b1; tick_sub = 1'b1;
        for (int i = 0; i < 3; i++) begin pin(1'b1); pin(1'b0); end
        rd16(v);                  check("R8 event count", v, 16'h000D);
        @(negedge clk); tick_div = 1'b0; tick_sub = 1'b0;

        // R10 coherent pair read while counting
        wr(2'd0, ctl(2'b00, 0, 0, 0, 0));
        wr16(16'h0100);
        @(negedge clk); rd_en = 1'b1; addr = 2'd1; tick_div = 1'b1;
        @(negedge clk); rd_en = 1'b0; b = rdata;
        check("R10 low byte", {8'h0, b}, 16'h0000);
        rd(2'd2, b);              check("R10 shadow high byte", {8'h0, b}, 16'h0001);
        @(negedge clk); tick_div = 1'b0;

        // R3/R4 random tick streams against the reference model
        for (int r = 0; r < 6; r++) begin
            logic [15:0] rl, m;
            bit sub;
            rl = 16'($urandom_range(0, 12));
            sub = 1'($urandom_range(0, 1));
            wr(2'd0, ctl(2'b00, 0, 0, 0, sub));
            wr16(rl);
            m = rl; exp_uf = 0; u0 = n_uf;
            for (int k = 0; k < 400; k++) begin
                bit td, ts;
                @(negedge clk);
                td = 1'($urandom_range(0, 1));
                ts = 1'($urandom_range(0, 1));
                tick_div = td; tick_sub = ts;
                if (sub ? ts : td) m = ref_step(m, rl, exp_uf);
            end
            @(negedge clk); tick_div = 1'b0; tick_sub = 1'b0;
            rd16(v);              check("R3 random count", v, m);
            check("R4 random underflows", 16'(n_uf - u0), 16'(exp_uf));
        end

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule